// File: doc/BRIEF.md
# Instruction Prefix Size Resolver

This block takes the byte stream of one instruction after another. Bytes arrive one per cycle on a valid/ready input. The block scans the size-related prefixes in front of each opcode and, for every instruction, reports three things:

- the effective operand size,
- the effective address size,
- whether a SIMD mandatory-prefix case applies.

Two plain control inputs set the context. One chooses the execution mode. The other carries the default-size flag of the code segment. Both are sampled in the cycle the opcode byte is accepted.

The result leaves on a valid/ready output. It appears in the cycle after the opcode byte is accepted, together with that opcode byte. The result stays registered until the consumer takes it. While a result is waiting and `out_ready` is low, `in_ready` is held low, so no byte of the next instruction is taken. A byte counts as accepted only on a rising edge where both `in_valid` and `in_ready` are high.

Top module: `prefix_size_resolver`

## Requirements

Encodings used below:

- Size fields: 00 = 16 bits, 01 = 32 bits, 10 = 64 bits.
- `mode_sel`: 00 = real / virtual-8086 / SMM, 01 = protected or compatibility, 10 = 64-bit, 11 = treated as 00.

Requirements:

- R1: With `mode_sel` 00 or 11 and no size prefix, both the operand size and the address size are 16 bits.
- R2: With `mode_sel` 01, the default operand size and address size are 32 bits when `d_flag` is 1 and 16 bits when `d_flag` is 0.
- R3: Outside 64-bit mode, byte 66h flips the operand size between 16 and 32 bits, and byte 67h independently flips the address size. Repeating a prefix has the same effect as a single copy. The bytes F0h, 26h, 2Eh, 36h, 3Eh, 64h and 65h are accepted as prefixes and change neither size.
- R4: In 64-bit mode, the address size is 64 bits, or 32 bits when 67h is present. It is never 16 bits. The default operand size is 32 bits.
- R5: Bytes 40h–4Fh are REX prefixes only in 64-bit mode; in any other mode they are opcodes. In 64-bit mode, a REX byte with bit 3 set gives a 64-bit operand size, and this wins over 66h. Without that bit, 66h gives a 16-bit operand size.
- R6: A REX byte that is followed by any legacy prefix byte is dropped and has no effect.
- R7: When the opcode byte is 0Fh and any of 66h, F2h or F3h preceded it, `out_simd_pfx` is 1 and 66h does not change the operand size. Otherwise `out_simd_pfx` is 0.
- R8: Prefix effects apply only to the instruction they precede. The state clears when the opcode is accepted, and the next instruction starts from the mode defaults.
- R9: `out_valid` rises in the cycle after an opcode byte is accepted, and `out_opcode` carries that byte. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values and `in_ready` is 0.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Execution mode select |
| d_flag | input | 1 | Code-segment default-size flag (used in protected mode) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_opsize | output | 2 | Effective operand size |
| out_adsize | output | 2 | Effective address size |
| out_simd_pfx | output | 1 | Mandatory SIMD prefix case |
| out_opcode | output | 8 | Opcode byte that ended the instruction |

## Verification

The bench targets several precedence corner cases:

- 66h together with REX.W in both orders. A design that let 66h win, or that kept a REX byte followed by a legacy prefix, would report 16 bits where 64 is expected, or the reverse.
- Bytes 40h–4Fh outside 64-bit mode must end the instruction. A design that took them as prefixes would never raise `out_valid`.
- With D set and both size prefixes present, both sizes must come out as 16 bits.
- Repeated 66h must count as a single prefix. A toggle-counting design would cancel the two copies.
- A 0Fh opcode with 66h in front must keep the default operand size.

Back-pressure is also exercised. A design that accepted bytes while a result was pending would lose or merge the stalled prefix, and the following instruction would come out with the wrong size.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_PROT   = 2'b01,
    MODE_LONG   = 2'b10,
    MODE_RSVD   = 2'b11
  } exec_mode_e;

  typedef enum logic [1:0] {
    SZ16 = 2'b00,
    SZ32 = 2'b01,
    SZ64 = 2'b10
  } size_e;

  typedef enum logic [2:0] {
    CLS_OPCODE = 3'd0,
    CLS_OPSZ   = 3'd1,
    CLS_ADSZ   = 3'd2,
    CLS_REP    = 3'd3,
    CLS_NEUTRAL = 3'd4,
    CLS_REX    = 3'd5
  } byte_cls_e;

  typedef struct packed {
    logic opsz;
    logic adsz;
    logic rep;
    logic rex_seen;
    logic rex_w;
  } pfx_state_t;

  localparam logic [7:0] B_OPSZ = 8'h66;
  localparam logic [7:0] B_ADSZ = 8'h67;
  localparam logic [7:0] B_REPNE = 8'hF2;
  localparam logic [7:0] B_REP  = 8'hF3;
  localparam logic [7:0] B_LOCK = 8'hF0;

  function automatic logic is_seg_override(input logic [7:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  function automatic size_e flip16_32(input size_e s, input logic flip);
    if (!flip) return s;
    return (s == SZ16) ? SZ32 : SZ16;
  endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [3:0] REX_NIBBLE = 4'h4
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              long_mode_i,
  output byte_cls_e         cls_o,
  output logic              rex_w_o
);

  localparam int HI = BYTE_W - 1;

  always_comb begin
    cls_o = CLS_OPCODE;
    if (byte_i == B_OPSZ)                            cls_o = CLS_OPSZ;
    else if (byte_i == B_ADSZ)                       cls_o = CLS_ADSZ;
    else if (byte_i == B_REP || byte_i == B_REPNE)   cls_o = CLS_REP;
    else if (byte_i == B_LOCK || is_seg_override(byte_i)) cls_o = CLS_NEUTRAL;
    else if (long_mode_i && byte_i[HI:HI-3] == REX_NIBBLE) cls_o = CLS_REX;
  end

  assign rex_w_o = byte_i[3];

endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  byte_cls_e  cls_i,
  input  logic       rex_w_i,
  output pfx_state_t st_o
);

  pfx_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (take_i) begin
      unique case (cls_i)
        CLS_OPCODE: st_d = '0;
        CLS_REX: begin
          st_d.rex_seen = 1'b1;
          st_d.rex_w    = rex_w_i;
        end
        default: begin
          // a REX byte must sit right before the opcode; a later legacy prefix voids it
          st_d.rex_seen = 1'b0;
          st_d.rex_w    = 1'b0;
          if (cls_i == CLS_OPSZ) st_d.opsz = 1'b1;
          if (cls_i == CLS_ADSZ) st_d.adsz = 1'b1;
          if (cls_i == CLS_REP)  st_d.rep  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  assert_clear_after_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && cls_i == CLS_OPCODE |=> st_q == '0);

  assert_rex_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && cls_i != CLS_OPCODE && cls_i != CLS_REX |=> !st_q.rex_w && !st_q.rex_seen);

endmodule

// File: rtl/pfx_resolve.sv
module pfx_resolve
  import pfx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SIMD_ESC = 8'h0F
) (
  input  exec_mode_e        mode_i,
  input  logic              d_i,
  input  pfx_state_t        st_i,
  input  logic [BYTE_W-1:0] opcode_i,
  output size_e             opsize_o,
  output size_e             adsize_o,
  output logic              simd_o
);

  logic  mandatory;
  size_e def_sz;

  assign mandatory = (opcode_i == SIMD_ESC) && (st_i.opsz || st_i.rep);

  always_comb begin
    def_sz   = SZ16;
    opsize_o = SZ16;
    adsize_o = SZ16;
    unique case (mode_i)
      MODE_PROT: begin
        def_sz   = d_i ? SZ32 : SZ16;
        opsize_o = flip16_32(def_sz, st_i.opsz && !mandatory);
        adsize_o = flip16_32(def_sz, st_i.adsz);
      end
      MODE_LONG: begin
        adsize_o = st_i.adsz ? SZ32 : SZ64;
        if (st_i.rex_w)                     opsize_o = SZ64;
        else if (st_i.opsz && !mandatory)   opsize_o = SZ16;
        else                                opsize_o = SZ32;
      end
      default: begin
        opsize_o = flip16_32(SZ16, st_i.opsz && !mandatory);
        adsize_o = flip16_32(SZ16, st_i.adsz);
      end
    endcase
  end

  assign simd_o = mandatory;

endmodule

// File: rtl/prefix_size_resolver.sv
module prefix_size_resolver
  import pfx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SIMD_ESC = 8'h0F,
  parameter logic [3:0] REX_NIBBLE = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              d_flag,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_opsize,
  output logic [1:0]        out_adsize,
  output logic              out_simd_pfx,
  output logic [BYTE_W-1:0] out_opcode
);

  exec_mode_e mode;
  byte_cls_e  cls;
  logic       rex_w_bit, take, take_op;
  pfx_state_t st;
  size_e      res_op, res_ad;
  logic       res_simd;

  assign mode = exec_mode_e'(mode_sel);

  pfx_classify #(.BYTE_W(BYTE_W), .REX_NIBBLE(REX_NIBBLE)) u_cls (
    .byte_i(in_byte), .long_mode_i(mode == MODE_LONG),
    .cls_o(cls), .rex_w_o(rex_w_bit)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign take_op  = take && (cls == CLS_OPCODE);

  pfx_accum u_acc (
    .clk(clk), .rst_n(rst_n), .take_i(take), .cls_i(cls),
    .rex_w_i(rex_w_bit), .st_o(st)
  );

  pfx_resolve #(.BYTE_W(BYTE_W), .SIMD_ESC(SIMD_ESC)) u_res (
    .mode_i(mode), .d_i(d_flag), .st_i(st), .opcode_i(in_byte),
    .opsize_o(res_op), .adsize_o(res_ad), .simd_o(res_simd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_opsize   <= SZ16;
      out_adsize   <= SZ16;
      out_simd_pfx <= 1'b0;
      out_opcode   <= '0;
    end else if (take_op) begin
      out_valid    <= 1'b1;
      out_opsize   <= res_op;
      out_adsize   <= res_ad;
      out_simd_pfx <= res_simd;
      out_opcode   <= in_byte;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opsize) &&
      $stable(out_adsize) && $stable(out_simd_pfx) && $stable(out_opcode));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_no_16bit_addr_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && mode == MODE_LONG |=> out_adsize != SZ16);

  assert_rexw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && mode == MODE_LONG && st.rex_w |=> out_opsize == SZ64);

  assert_no_64_outside_long_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && mode != MODE_LONG |=> out_opsize != SZ64 && out_adsize != SZ64);

  assert_valid_after_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_op |=> out_valid && out_opcode == $past(in_byte));

endmodule

// File: tb/prefix_size_resolver_bench.sv
module prefix_size_resolver_bench;

  typedef struct packed {
    logic [1:0]  mode;
    logic        d;
    logic [2:0]  n;
    logic [31:0] bytes;
    logic [1:0]  eop;
    logic [1:0]  ead;
    logic        esimd;
  } vec_t;

  localparam int NV = 23;
  // sizes: 0=16 1=32 2=64 ; first byte in bits 31:24, last sent byte is the opcode
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 3'd1, 32'h90000000, 2'd0, 2'd0, 1'b0}, // R1
    '{2'd0, 1'b0, 3'd2, 32'h66900000, 2'd1, 2'd0, 1'b0}, // R3
    '{2'd0, 1'b0, 3'd2, 32'h678B0000, 2'd0, 2'd1, 1'b0}, // R3 R8
    '{2'd1, 1'b0, 3'd3, 32'h66678B00, 2'd1, 2'd1, 1'b0}, // R2 R3
    '{2'd1, 1'b1, 3'd1, 32'h8B000000, 2'd1, 2'd1, 1'b0}, // R2
    '{2'd1, 1'b1, 3'd3, 32'h66678B00, 2'd0, 2'd0, 1'b0}, // R3
    '{2'd1, 1'b1, 3'd2, 32'h678B0000, 2'd1, 2'd0, 1'b0}, // R3
    '{2'd1, 1'b1, 3'd2, 32'h668B0000, 2'd0, 2'd1, 1'b0}, // R3
    '{2'd2, 1'b0, 3'd1, 32'h8B000000, 2'd1, 2'd2, 1'b0}, // R4
    '{2'd2, 1'b0, 3'd2, 32'h488B0000, 2'd2, 2'd2, 1'b0}, // R5
    '{2'd2, 1'b0, 3'd3, 32'h66488B00, 2'd2, 2'd2, 1'b0}, // R5 precedence
    '{2'd2, 1'b1, 3'd2, 32'h668B0000, 2'd0, 2'd2, 1'b0}, // R5
    '{2'd2, 1'b0, 3'd2, 32'h678B0000, 2'd1, 2'd1, 1'b0}, // R4
    '{2'd2, 1'b0, 3'd3, 32'h48668B00, 2'd0, 2'd2, 1'b0}, // R6
    '{2'd1, 1'b1, 3'd1, 32'h48000000, 2'd1, 2'd1, 1'b0}, // R5 REX byte is opcode
    '{2'd2, 1'b0, 3'd2, 32'h660F0000, 2'd1, 2'd2, 1'b1}, // R7
    '{2'd2, 1'b0, 3'd3, 32'h66480F00, 2'd2, 2'd2, 1'b1}, // R7
    '{2'd1, 1'b0, 3'd2, 32'hF30F0000, 2'd0, 2'd0, 1'b1}, // R7
    '{2'd1, 1'b0, 3'd2, 32'h660F0000, 2'd0, 2'd0, 1'b1}, // R7 no toggle
    '{2'd2, 1'b0, 3'd4, 32'h2E66648B, 2'd0, 2'd2, 1'b0}, // R3 neutral prefixes
    '{2'd0, 1'b0, 3'd4, 32'h66666790, 2'd1, 2'd1, 1'b0}, // R3 repeats
    '{2'd2, 1'b0, 3'd2, 32'h418B0000, 2'd1, 2'd2, 1'b0}, // R5 REX without W
    '{2'd3, 1'b0, 3'd1, 32'h8B000000, 2'd0, 2'd0, 1'b0}  // R1 reserved mode
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       d_flag = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_simd_pfx;
  logic [1:0] out_opsize, out_adsize;
  logic [7:0] out_opcode;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  prefix_size_resolver u_prefix_size_resolver (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .d_flag(d_flag),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_opsize(out_opsize), .out_adsize(out_adsize),
    .out_simd_pfx(out_simd_pfx), .out_opcode(out_opcode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid", 32'(out_valid), 32'd0);
    check("R10 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_sel = VECS[v].mode;
      d_flag   = VECS[v].d;
      for (int i = 0; i < int'(VECS[v].n); i++)
        send(VECS[v].bytes[31-8*i -: 8]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 vec%0d valid", v), 32'(out_valid), 32'd1);
      check($sformatf("R1-5 vec%0d opsize", v), 32'(out_opsize), 32'(VECS[v].eop));
      check($sformatf("R4 vec%0d adsize", v), 32'(out_adsize), 32'(VECS[v].ead));
      check($sformatf("R7 vec%0d simd", v), 32'(out_simd_pfx), 32'(VECS[v].esimd));
      check($sformatf("R9 vec%0d opcode", v),
            32'(out_opcode), 32'(VECS[v].bytes[31-8*(int'(VECS[v].n)-1) -: 8]));
      @(negedge clk);
      check($sformatf("R9 vec%0d consumed", v), 32'(out_valid), 32'd0);
    end

    // R8: prefix state from one instruction must not leak into the next
    @(negedge clk);
    mode_sel = 2'd0;
    send(8'h66);
    send(8'h90);
    send(8'h90);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next instr back to default", 32'(out_opsize), 32'd0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(8'h90);
    @(negedge clk);
    in_byte = 8'h66;
    check("R9 stalled valid", 32'(out_valid), 32'd1);
    check("R9 stalled in_ready", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R9 still held", 32'(out_valid), 32'd1);
    check("R9 opcode held", 32'(out_opcode), 32'h90);
    check("R9 opsize held", 32'(out_opsize), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 32'(out_valid), 32'd0);
    in_byte = 8'h90;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 stalled prefix taken once", 32'(out_opsize), 32'd1);
    check("R9 stalled result valid", 32'(out_valid), 32'd1);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule